// File: doc/BRIEF.md
# Waveform Display Raster Controller

This block scans a monochrome LCD row by row, from the top row to the bottom row, and produces one pixel at a time together with a line sync and a frame sync. Each pixel combines two sources. One is an overlay bitplane that holds the cursor, graticule and text, with one bit per pixel. The other is a trace stored as a single amplitude byte per screen column. The block turns that amplitude into lit pixels while the row is scanned. The trace can be drawn as a one-, two- or three-pixel dot. It can also be drawn as a joined line that fills the vertical gap between neighbouring columns.

Both sources are held in a byte-wide memory that a processor also uses. The block reads this memory through a request/grant port. It fetches nine bytes for every eight-pixel group: the overlay byte first, then eight trace bytes. These go into one half of a two-entry buffer while the other half feeds the pixel output. Because of this, the pixel cadence holds when the processor takes the memory for a bounded number of cycles. Parameters set the panel size, the clocks per pixel and the length of the line sync. COLS must be a multiple of 8, ROWS must be at most 256, PIX_CLKS must be at least 2, and LINE_CLKS must be at least 8*PIX_CLKS.

Top module: `wave_raster`

## Requirements
- R1: line_sync is high for exactly LINE_CLKS cycles at the start of every row. Consecutive rises of line_sync are LINE_CLKS + COLS*PIX_CLKS cycles apart.
- R2: frame_sync is high for exactly one row period, starting in the same cycle as row 0's line_sync rise.
- R3: Each row gives COLS single-cycle pix_valid strobes from left to right. Strobe k (k counted from 0) comes LINE_CLKS + k*PIX_CLKS cycles after that row's line_sync rise.
- R4: The overlay byte for row r and group g is read from address r*(COLS/8)+g. Bit b of that byte is column 8g+b. A set bit lights the pixel whatever the trace does.
- R5: The trace byte for column c is read from address ROWS*(COLS/8)+c. Amplitude v maps to level v, and the pixel in row r sits at level ROWS-1-r. With dot_size 0 or 1, only the pixel whose level equals v is lit. A value at or above ROWS lights nothing.
- R6: With dot_size 2, levels v and v+1 are lit. With dot_size 3, levels v-1, v and v+1 are lit.
- R7: With join_en high, column c lights every level from min(v, p) to max(v, p), widened as in R6. Here p is the amplitude of column c-1, and for column 0 p equals v.
- R8: While mem_req is high and mem_gnt is low, the next cycle keeps mem_req high and mem_addr unchanged. Read data is taken from mem_rdata in the cycle after a granted request.
- R9: Pixel data and cadence are unchanged as long as the grant is withheld for no more than 8*PIX_CLKS-10 cycles while one eight-pixel group is being fetched.
- R10: Reset is synchronous and active high. While it is held, line_sync and frame_sync are high and pix_valid is low, and output restarts at row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_size | input | 2 | Trace dot height: 0/1 one pixel, 2 two pixels, 3 three pixels |
| join_en | input | 1 | Draws the trace as a joined vertical line between columns |
| mem_req | output | 1 | Read request to the shared memory |
| mem_addr | output | AW | Read byte address |
| mem_gnt | input | 1 | Grant; a request is accepted in a cycle where both are high |
| mem_rdata | input | 8 | Read data, valid the cycle after a grant |
| line_sync | output | 1 | Line pulse at the start of every row |
| frame_sync | output | 1 | Frame pulse covering row 0 |
| pix_valid | output | 1 | One-cycle strobe per pixel |
| pix_on | output | 1 | Pixel value, meaningful when pix_valid is high |

## Verification
The assertions check these properties on every cycle:
- the line sync length and the first pixel that follows it;
- frame sync starting together with a line sync;
- request and address held through a denied grant;
- no pixel emitted from a buffer that has not been filled;
- an overlay bit always lighting its pixel.

Only the bench's scenarios can show that each pixel has the right value for each dot size and join setting, including column 0 and amplitudes beyond the panel. The same applies to exact pixel timing and to the data staying correct under several grant-denial patterns.

// File: rtl/wraster_pkg.sv
package wraster_pkg;

    localparam int GRP_PIX = 8;

    typedef logic [7:0] tval_t;

    typedef struct packed {
        tval_t [GRP_PIX-1:0]  trace;
        logic  [GRP_PIX-1:0]  ovl;
    } grp_t;

    typedef enum logic [1:0] {
        DOT_SINGLE0 = 2'd0,
        DOT_SINGLE  = 2'd1,
        DOT_DOUBLE  = 2'd2,
        DOT_TRIPLE  = 2'd3
    } dot_e;

    // Level 0 is the bottom row. Span covers the sample (or the joined
    // range) extended down by one for triple dots and up by one for
    // double and triple dots.
    function automatic logic trace_hit(
        input logic [8:0] level,
        input tval_t      cur,
        input tval_t      prv,
        input dot_e       size,
        input logic       join_on
    );
        logic [8:0] lo, hi, up, dn;
        lo = (join_on && (prv < cur)) ? {1'b0, prv} : {1'b0, cur};
        hi = (join_on && (prv > cur)) ? {1'b0, prv} : {1'b0, cur};
        up = (size == DOT_DOUBLE || size == DOT_TRIPLE) ? 9'd1 : 9'd0;
        dn = (size == DOT_TRIPLE) ? 9'd1 : 9'd0;
        return ((level + dn) >= lo) && (level <= (hi + up));
    endfunction

endpackage

// File: rtl/wraster_scan.sv
module wraster_scan
    import wraster_pkg::*;
#(
    parameter int COLS      = 240,
    parameter int ROWS      = 240,
    parameter int PIX_CLKS  = 2,
    parameter int LINE_CLKS = 16,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          line_sync,
    output logic          frame_sync,
    output logic          pix_valid,
    output logic          pix_end,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row
);
    localparam int SW = $clog2(PIX_CLKS);
    localparam int LW = $clog2(LINE_CLKS);

    logic          in_sync;
    logic [LW-1:0] cnt;
    logic [SW-1:0] sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sync <= 1'b1;
            cnt     <= '0;
            sub     <= '0;
            col     <= '0;
            row     <= '0;
        end else if (in_sync) begin
            if (cnt == LW'(LINE_CLKS - 1)) begin
                in_sync <= 1'b0;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (sub == SW'(PIX_CLKS - 1)) begin
            sub <= '0;
            if (col == CW'(COLS - 1)) begin
                col     <= '0;
                in_sync <= 1'b1;
                row     <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end else begin
            sub <= sub + 1'b1;
        end
    end

    assign line_sync  = in_sync;
    assign frame_sync = (row == '0);
    assign pix_valid  = !in_sync && (sub == '0);
    assign pix_end    = !in_sync && (sub == SW'(PIX_CLKS - 1));

    // Checker state: number of consecutive cycles with line_sync high.
    logic [LW:0] sync_run;
    always_ff @(posedge clk) begin
        if (rst)          sync_run <= '0;
        else if (in_sync) sync_run <= sync_run + 1'b1;
        else              sync_run <= '0;
    end

    a_r1_sync_length: assert property (@(posedge clk) disable iff (rst)
        $fell(line_sync) |-> (sync_run == (LW+1)'(LINE_CLKS)));

    a_r3_pixel_follows_sync: assert property (@(posedge clk) disable iff (rst)
        $fell(line_sync) |-> pix_valid);

    a_r2_frame_with_line: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_sync) |-> line_sync);

endmodule

// File: rtl/wraster_fetch.sv
module wraster_fetch
    import wraster_pkg::*;
#(
    parameter int COLS = 240,
    parameter int ROWS = 240,
    parameter int AW   = 16
) (
    input  logic          clk,
    input  logic          rst,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic [7:0]    mem_rdata,
    input  logic          release_i,
    output grp_t          cur_grp,
    output logic          cur_full
);
    localparam int GROUPS     = COLS / GRP_PIX;
    localparam int GW         = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int RW         = $clog2(ROWS);
    localparam int TRACE_BASE = ROWS * GROUPS;
    localparam int IW         = 4;
    localparam logic [IW-1:0] IDX_DONE = IW'(GRP_PIX + 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(GRP_PIX);

    grp_t          bufs [2];
    logic [1:0]    full;
    logic          fill_sel, cons_sel;
    logic [IW-1:0] f_idx, rd_idx;
    logic          rd_pend;
    logic [RW-1:0] f_row;
    logic [GW-1:0] f_grp;
    logic [AW-1:0] ovl_addr, trc_addr;
    logic [2:0]    lane_w;

    assign mem_req = !full[fill_sel] && (f_idx != IDX_DONE);

    always_comb begin
        ovl_addr = AW'(f_row) * AW'(GROUPS) + AW'(f_grp);
        trc_addr = AW'(TRACE_BASE) + (AW'(f_grp) << 3) + AW'(f_idx - 4'd1);
        mem_addr = (f_idx == '0) ? ovl_addr : trc_addr;
    end

    assign lane_w = 3'(rd_idx - 4'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bufs[0]  <= '0;
            bufs[1]  <= '0;
            full     <= '0;
            fill_sel <= 1'b0;
            cons_sel <= 1'b0;
            f_idx    <= '0;
            rd_idx   <= '0;
            rd_pend  <= 1'b0;
            f_row    <= '0;
            f_grp    <= '0;
        end else begin
            if (mem_req && mem_gnt) begin
                f_idx   <= f_idx + 1'b1;
                rd_pend <= 1'b1;
                rd_idx  <= f_idx;
            end else begin
                rd_pend <= 1'b0;
            end

            if (rd_pend) begin
                if (rd_idx == '0) bufs[fill_sel].ovl <= mem_rdata;
                else              bufs[fill_sel].trace[lane_w] <= mem_rdata;
                if (rd_idx == IDX_LAST) begin
                    full[fill_sel] <= 1'b1;
                    fill_sel       <= ~fill_sel;
                    f_idx          <= '0;
                    if (f_grp == GW'(GROUPS - 1)) begin
                        f_grp <= '0;
                        f_row <= (f_row == RW'(ROWS - 1)) ? '0 : f_row + 1'b1;
                    end else begin
                        f_grp <= f_grp + 1'b1;
                    end
                end
            end

            if (release_i) begin
                full[cons_sel] <= 1'b0;
                cons_sel       <= ~cons_sel;
            end
        end
    end

    assign cur_grp  = bufs[cons_sel];
    assign cur_full = full[cons_sel];

    a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: rtl/wraster_pixel.sv
module wraster_pixel
    import wraster_pkg::*;
#(
    parameter int ROWS = 240,
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  grp_t          grp,
    input  logic [2:0]    lane,
    input  logic          col_zero,
    input  logic [RW-1:0] row,
    input  logic          pix_valid,
    input  logic          pix_end,
    input  logic [1:0]    dot_size,
    input  logic          join_en,
    output logic          pix_on
);
    tval_t      prev_val;
    tval_t      cur_val;
    tval_t      nb_val;
    logic [8:0] level;
    logic       hit;

    assign cur_val = grp.trace[lane];
    assign nb_val  = col_zero ? cur_val : prev_val;
    assign level   = 9'(ROWS - 1) - 9'(row);
    assign hit     = trace_hit(level, cur_val, nb_val, dot_e'(dot_size), join_en);
    assign pix_on  = pix_valid && (grp.ovl[lane] || hit);

    always_ff @(posedge clk) begin
        if (rst)          prev_val <= '0;
        else if (pix_end) prev_val <= cur_val;
    end

endmodule

// File: rtl/wave_raster.sv
module wave_raster
    import wraster_pkg::*;
#(
    parameter int COLS      = 240,
    parameter int ROWS      = 240,
    parameter int PIX_CLKS  = 2,
    parameter int LINE_CLKS = 16,
    parameter int AW        = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    dot_size,
    input  logic          join_en,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic [7:0]    mem_rdata,
    output logic          line_sync,
    output logic          frame_sync,
    output logic          pix_valid,
    output logic          pix_on
);
    localparam int CW = $clog2(COLS);
    localparam int RW = $clog2(ROWS);

    logic          pix_end;
    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic          grp_done;
    grp_t          cur_grp;
    logic          cur_full;

    assign grp_done = pix_end && (col[2:0] == 3'd7);

    wraster_scan #(
        .COLS(COLS), .ROWS(ROWS), .PIX_CLKS(PIX_CLKS), .LINE_CLKS(LINE_CLKS)
    ) u_scan (
        .clk(clk), .rst(rst),
        .line_sync(line_sync), .frame_sync(frame_sync),
        .pix_valid(pix_valid), .pix_end(pix_end),
        .col(col), .row(row)
    );

    wraster_fetch #(
        .COLS(COLS), .ROWS(ROWS), .AW(AW)
    ) u_fetch (
        .clk(clk), .rst(rst),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .release_i(grp_done),
        .cur_grp(cur_grp), .cur_full(cur_full)
    );

    wraster_pixel #(
        .ROWS(ROWS)
    ) u_pixel (
        .clk(clk), .rst(rst),
        .grp(cur_grp), .lane(col[2:0]), .col_zero(col == '0),
        .row(row), .pix_valid(pix_valid), .pix_end(pix_end),
        .dot_size(dot_size), .join_en(join_en),
        .pix_on(pix_on)
    );

    a_r9_no_underrun: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> cur_full);

    a_r4_overlay_lights: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && cur_grp.ovl[col[2:0]]) |-> pix_on);

endmodule

// File: tb/wave_raster_test.sv
module wave_raster_test;
    localparam int COLS       = 16;
    localparam int ROWS       = 8;
    localparam int PIX_CLKS   = 2;
    localparam int LINE_CLKS  = 16;
    localparam int AW         = 8;
    localparam int GROUPS     = COLS / 8;
    localparam int TBASE      = ROWS * GROUPS;
    localparam int ROW_PERIOD = LINE_CLKS + COLS * PIX_CLKS;
    localparam int FRAME      = ROWS * ROW_PERIOD;

    typedef struct {
        int    row;
        int    col;
        bit    on;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    dot_size = 2'd1;
    logic          join_en = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_gnt = 1'b1;
    logic [7:0]    mem_rdata = 8'd0;
    logic          line_sync, frame_sync, pix_valid, pix_on;

    logic [7:0] mem [0:255];
    exp_t       sb_q[$];
    int checks = 0;
    int errors = 0;
    int stall_mode = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    wave_raster #(
        .COLS(COLS), .ROWS(ROWS), .PIX_CLKS(PIX_CLKS),
        .LINE_CLKS(LINE_CLKS), .AW(AW)
    ) uut (
        .clk(clk), .rst(rst), .dot_size(dot_size), .join_en(join_en),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .line_sync(line_sync), .frame_sync(frame_sync),
        .pix_valid(pix_valid), .pix_on(pix_on)
    );

    always #5 clk = ~clk;

    // Memory model: one-cycle read latency after a grant.
    always @(posedge clk) begin
        if (mem_req && mem_gnt) mem_rdata <= mem[mem_addr];
    end

    // Grant pattern, driven away from the active edge.
    initial begin
        int gcyc;
        gcyc = 0;
        forever begin
            @(negedge clk);
            gcyc++;
            case (stall_mode)
                1:       mem_gnt = (gcyc % 4) != 0;
                2:       mem_gnt = (gcyc % 32) >= 5;
                default: mem_gnt = 1'b1;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: samples one time unit after each falling edge.
    initial begin
        int  since_rise, ls_run, fs_run, pix_k;
        bit  prev_ls, prev_fs, have_rise, prev_stall;
        logic [AW-1:0] prev_addr;
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (!mon_on) continue;
            if (rst) begin
                since_rise = 0; ls_run = 0; fs_run = 0; pix_k = 0;
                prev_ls = 0; prev_fs = 0; have_rise = 0; prev_stall = 0;
                continue;
            end
            since_rise++;
            // R8: a denied request is held with the same address
            if (prev_stall)
                check(mem_req && (mem_addr == prev_addr), "R8", int'(mem_addr), int'(prev_addr));
            prev_stall = mem_req && !mem_gnt;
            prev_addr  = mem_addr;

            if (line_sync) begin
                ls_run++;
                if (!prev_ls) begin
                    // R1: row period between line pulses
                    if (have_rise) check(since_rise == ROW_PERIOD, "R1", since_rise, ROW_PERIOD);
                    since_rise = 0;
                    have_rise  = 1;
                    pix_k      = 0;
                end
            end else if (prev_ls) begin
                check(ls_run == LINE_CLKS, "R1", ls_run, LINE_CLKS);
                ls_run = 0;
            end
            prev_ls = line_sync;

            if (frame_sync) begin
                fs_run++;
                if (!prev_fs) check(line_sync == 1'b1, "R2", int'(line_sync), 1);
            end else if (prev_fs) begin
                check(fs_run == ROW_PERIOD, "R2", fs_run, ROW_PERIOD);
                fs_run = 0;
            end
            prev_fs = frame_sync;

            if (pix_valid) begin
                // R3: pixel k position inside its row
                check(since_rise == LINE_CLKS + pix_k * PIX_CLKS, "R3",
                      since_rise, LINE_CLKS + pix_k * PIX_CLKS);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check(pix_on == e.on, e.tag, int'(pix_on), int'(e.on));
                end
                pix_k++;
            end
        end
    end

    function automatic bit exp_pixel(input int r, input int c, input int ds, input bit jn);
        int v, p, lo, hi, lvl;
        v   = mem[TBASE + c];
        p   = (c == 0) ? v : mem[TBASE + c - 1];
        lo  = v; hi = v;
        if (jn) begin
            if (p < lo) lo = p;
            if (p > hi) hi = p;
        end
        if (ds == 3) lo = lo - 1;
        if (ds >= 2) hi = hi + 1;
        lvl = ROWS - 1 - r;
        return (lvl >= lo) && (lvl <= hi);
    endfunction

    task automatic run_frame(input int sm, input int ds, input bit jn, input int unsigned seed);
        int unsigned st;
        exp_t e;
        bit ob;
        @(negedge clk);
        rst = 1'b1;
        mon_on = 1'b1;
        stall_mode = sm;
        dot_size = 2'(ds);
        join_en = jn;
        st = seed;
        for (int i = 0; i < 256; i++) mem[i] = 8'd0;
        for (int i = 0; i < TBASE; i++) begin
            st = st * 32'd1103515245 + 32'd12345;
            mem[i] = 8'((st >> 8) & (st >> 16) & (st >> 21));
        end
        for (int c = 0; c < COLS; c++) begin
            st = st * 32'd1103515245 + 32'd12345;
            mem[TBASE + c] = ((st >> 16) % (ROWS + 3) == ROWS + 2) ? 8'd200
                             : 8'((st >> 16) % (ROWS + 3));
        end
        sb_q.delete();
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                ob = mem[r * GROUPS + c / 8][c % 8];
                e.row = r;
                e.col = c;
                e.on  = ob || exp_pixel(r, c, ds, jn);
                e.tag = ob ? "R4" : (jn ? "R7" : (ds >= 2 ? "R6" : "R5"));
                sb_q.push_back(e);
            end
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(pix_valid == 1'b0, "R10", int'(pix_valid), 0);
        check(line_sync == 1'b1, "R10", int'(line_sync), 1);
        check(frame_sync == 1'b1, "R10", int'(frame_sync), 1);
        rst = 1'b0;
        repeat (FRAME + LINE_CLKS / 2) @(negedge clk);
        mon_on = 1'b0;
        // R3: every expected pixel was produced
        check(sb_q.size() == 0, "R3", sb_q.size(), 0);
    endtask

    initial begin
        run_frame(0, 1, 1'b0, 32'd11);   // R5 single dots, no stalls
        run_frame(1, 3, 1'b1, 32'd23);   // R7 R6 joined triple dots, R9 periodic stalls
        run_frame(2, 2, 1'b0, 32'd37);   // R6 double dots, R9 burst stalls
        run_frame(2, 0, 1'b1, 32'd51);   // R7 joined single dots, R9 burst stalls
        run_frame(0, 1, 1'b1, 32'd77);   // R7 column 0 uses its own value
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule